// File: doc/BRIEF.md
# Disc Channel Control and Write Interlock

This block holds the control and handshake state of a disc data channel that a host computer drives through I/O strobes and a DMA engine. The host sets the channel's control bit to start a transfer. The control bit starts the run state, and the run state qualifies the read and write paths. The block also keeps a service flag that asks the DMA engine to move the next word. A track address register is loaded from a host output word sent to the channel's command address.

Stopping is deferred. A clear of the control bit does not end the transfer. The run state stays active until the sector in progress reports its end. Writing is also gated by a power-good level. This level is low while power comes up and while it goes down.

The power-on or preset clear arrives as a train of pulses. Each pulse restarts a hold-off window of `HOLD_CYCLES` clock cycles. This count stands in for the roughly 40 ms interval. While the window is open, the control bit cannot be set, so a gap between pulses cannot start a transfer.

Top module: `disc_chan_ctl`

## Requirements
- R1: A `host_stc` strobe with `dat_sel` high sets `ctl_bit` at the next clock edge, unless a clear or a hold-off window applies in that cycle.
- R2: `dma_clc`, or `host_clc` with `dat_sel` high, clears `ctl_bit` at the next edge. When a set and a clear arrive in the same cycle, the clear wins.
- R3: `run` becomes 1 at the edge after the edge that finds `ctl_bit` at 1. While `ctl_bit` stays 1, `run` stays 1 across `sector_end` pulses.
- R4: After `ctl_bit` is 0, `run` stays 1 until an edge with `sector_end` high. That edge clears it.
- R5: `svc_req` sets `svc_flag` at the next edge, but only while `run` is 1. `dma_clf`, or `host_clf` with `dat_sel` high, clears it. If a request and a clear arrive in the same cycle, the request wins.
- R6: A `preset_pulse` cycle clears `ctl_bit`, `run` and `svc_flag` at the next edge. It also reloads the hold-off window, during which `host_stc` has no effect. The window ends `HOLD_CYCLES` edges after the last pulse.
- R7: `read_en` is `run & ~wr_mode`. `write_en` is `run & wr_mode & pwr_ok`. Both outputs are 0 whenever `run` is 0.
- R8: While `pwr_ok` is low, `write_en` is 0 in the same cycle, whatever the other inputs are.
- R9: `host_ota` with `cmd_sel` high loads `host_data[13:7]` into `track` at the next edge, with data bit 7 going to `track[0]`.
- R10: `track` keeps its value across preset pulses, the end of an operation and every other cycle, until the next R9 load. A synchronous reset sets it to 0.
- R11: `host_stc`, `host_clc` and `host_clf` without `dat_sel`, and `host_ota` without `cmd_sel`, leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| preset_pulse | input | 1 | Power-on / preset clear pulse (active high, repeats) |
| pwr_ok | input | 1 | Power-good level; low blocks writing |
| dat_sel | input | 1 | Host strobe addresses this data channel |
| cmd_sel | input | 1 | Host strobe addresses the command address |
| host_stc | input | 1 | Host set-control strobe |
| host_clc | input | 1 | Host clear-control strobe |
| host_clf | input | 1 | Host clear-flag strobe |
| host_ota | input | 1 | Host output-word strobe |
| host_data | input | DATA_W | Host output word |
| dma_clc | input | 1 | DMA clear-control strobe |
| dma_clf | input | 1 | DMA clear-flag strobe |
| svc_req | input | 1 | Data path needs or holds a word |
| sector_end | input | 1 | End of the current sector |
| wr_mode | input | 1 | 1 = write operation, 0 = read |
| ctl_bit | output | 1 | Control bit |
| run | output | 1 | Transfer in progress |
| svc_flag | output | 1 | Service request to DMA |
| track | output | TRK_W | Track address |
| read_en | output | 1 | Read qualifier |
| write_en | output | 1 | Write qualifier |

## Verification
Most internal faults show up at the ports within one or two edges. A wrong control bit shows on `ctl_bit` at the next edge and on `run` one edge later. A `run` that does not wait for the sector end stays hidden until a clear arrives, and it then shows on `run` and the enables at the very next edge. A hold-off counter that is off by one shows only when a set-control strobe lands at the edge of the window, so directed strobes are placed right at that boundary. Power gating is combinational and is checked in the same cycle that `pwr_ok` changes.

// File: rtl/disc_chan_pkg.sv
// Package: shared types for the disc channel control block.
// Assumes: strobes are single-cycle, synchronous to clk.
package disc_chan_pkg;

    // Decoded, address-qualified command strobes for one cycle.
    typedef struct packed {
        logic set_ctl;
        logic clr_ctl;
        logic clr_flag;
        logic load_trk;
    } chan_cmd_t;

endpackage

// File: rtl/chan_strobe_decode.sv
// Module: qualifies host strobes with their select lines and merges the DMA strobes.
// Assumes: dat_sel / cmd_sel are valid in the same cycle as the strobe.
module chan_strobe_decode
    import disc_chan_pkg::*;
(
    input  logic      dat_sel,
    input  logic      cmd_sel,
    input  logic      host_stc,
    input  logic      host_clc,
    input  logic      host_clf,
    input  logic      host_ota,
    input  logic      dma_clc,
    input  logic      dma_clf,
    output chan_cmd_t cmd
);

    // Combine each strobe with the select that addresses it.
    always_comb begin
        cmd          = '0;
        cmd.set_ctl  = host_stc & dat_sel;
        cmd.clr_ctl  = dma_clc | (host_clc & dat_sel);
        cmd.clr_flag = dma_clf | (host_clf & dat_sel);
        cmd.load_trk = host_ota & cmd_sel;
    end

endmodule

// File: rtl/chan_power_guard.sv
// Module: power-on hold-off window and read/write qualifier gating.
// Each preset pulse reloads a down-counter. While the counter is non-zero the
// control bit may not be set, which covers gaps in the preset pulse train.
// Assumes: HOLD_CYCLES >= 1.
module chan_power_guard #(
    parameter int HOLD_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset_pulse,
    input  logic pwr_ok,
    input  logic run,
    input  logic wr_mode,
    output logic hold_active,
    output logic read_en,
    output logic write_en
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] hold_cnt;

    // Reload on every preset pulse, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (preset_pulse) begin
            hold_cnt <= CNT_LOAD;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - CNT_ONE;
        end
    end

    assign hold_active = (hold_cnt != '0);

    // Qualifiers: both need run; writing additionally needs power good.
    always_comb begin
        read_en  = run & ~wr_mode;
        write_en = run & wr_mode & pwr_ok;
    end

endmodule

// File: rtl/chan_ctl_seq.sv
// Module: control bit, run state and service flag sequencing.
// A clear of the control bit lets the run state finish the current sector.
// Assumes: preset_pulse has priority over every strobe.
module chan_ctl_seq
    import disc_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      preset_pulse,
    input  logic      hold_active,
    input  chan_cmd_t cmd,
    input  logic      svc_req,
    input  logic      sector_end,
    output logic      ctl_bit,
    output logic      run,
    output logic      svc_flag
);

    // Control bit: clear beats set; set blocked during hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n || preset_pulse) begin
            ctl_bit <= 1'b0;
        end else if (cmd.clr_ctl) begin
            ctl_bit <= 1'b0;
        end else if (cmd.set_ctl && !hold_active) begin
            ctl_bit <= 1'b1;
        end
    end

    // Run state: follows a set control bit, drops only at a sector end.
    always_ff @(posedge clk) begin
        if (!rst_n || preset_pulse) begin
            run <= 1'b0;
        end else if (ctl_bit) begin
            run <= 1'b1;
        end else if (sector_end) begin
            run <= 1'b0;
        end
    end

    // Service flag: a request while running beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || preset_pulse) begin
            svc_flag <= 1'b0;
        end else if (svc_req && run) begin
            svc_flag <= 1'b1;
        end else if (cmd.clr_flag) begin
            svc_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/chan_track_reg.sv
// Module: track address register loaded from a field of the host word.
// Assumes: TRK_LSB + TRK_W <= DATA_W.
module chan_track_reg #(
    parameter int DATA_W  = 16,
    parameter int TRK_W   = 7,
    parameter int TRK_LSB = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    output logic [TRK_W-1:0]  track
);

    logic [TRK_W-1:0] field;
    logic             unused_data;

    // Pick the address field bit by bit, lowest data bit to track bit 0.
    for (genvar i = 0; i < TRK_W; i++) begin : g_field
        assign field[i] = data_in[TRK_LSB + i];
    end

    assign unused_data = ^data_in;

    // Hold the address until the next load; reset only by rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track <= '0;
        end else if (load) begin
            track <= field;
        end
    end

endmodule

// File: rtl/disc_chan_ctl.sv
// Module: top of the disc channel control and write interlock.
// Wires the strobe decoder, sequencer, track register and power guard.
// Assumes: all inputs synchronous to clk; rst_n is synchronous, active low.
module disc_chan_ctl
    import disc_chan_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TRK_W       = 7,
    parameter int TRK_LSB     = 7,
    parameter int HOLD_CYCLES = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_pulse,
    input  logic              pwr_ok,
    input  logic              dat_sel,
    input  logic              cmd_sel,
    input  logic              host_stc,
    input  logic              host_clc,
    input  logic              host_clf,
    input  logic              host_ota,
    input  logic [DATA_W-1:0] host_data,
    input  logic              dma_clc,
    input  logic              dma_clf,
    input  logic              svc_req,
    input  logic              sector_end,
    input  logic              wr_mode,
    output logic              ctl_bit,
    output logic              run,
    output logic              svc_flag,
    output logic [TRK_W-1:0]  track,
    output logic              read_en,
    output logic              write_en
);

    chan_cmd_t cmd;
    logic      hold_act;

    chan_strobe_decode u_decode (
        .dat_sel  (dat_sel),
        .cmd_sel  (cmd_sel),
        .host_stc (host_stc),
        .host_clc (host_clc),
        .host_clf (host_clf),
        .host_ota (host_ota),
        .dma_clc  (dma_clc),
        .dma_clf  (dma_clf),
        .cmd      (cmd)
    );

    chan_power_guard #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .preset_pulse (preset_pulse),
        .pwr_ok       (pwr_ok),
        .run          (run),
        .wr_mode      (wr_mode),
        .hold_active  (hold_act),
        .read_en      (read_en),
        .write_en     (write_en)
    );

    chan_ctl_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .preset_pulse (preset_pulse),
        .hold_active  (hold_act),
        .cmd          (cmd),
        .svc_req      (svc_req),
        .sector_end   (sector_end),
        .ctl_bit      (ctl_bit),
        .run          (run),
        .svc_flag     (svc_flag)
    );

    chan_track_reg #(
        .DATA_W  (DATA_W),
        .TRK_W   (TRK_W),
        .TRK_LSB (TRK_LSB)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd.load_trk),
        .data_in (host_data),
        .track   (track)
    );

endmodule

// File: rtl/disc_chan_ctl_chk.sv
// Module: protocol checker for disc_chan_ctl, attached by bind.
// Assumes: bound into every instance of disc_chan_ctl.
module disc_chan_ctl_chk #(
    parameter int DATA_W  = 16,
    parameter int TRK_W   = 7,
    parameter int TRK_LSB = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              preset_pulse,
    input logic              pwr_ok,
    input logic              dat_sel,
    input logic              cmd_sel,
    input logic              host_stc,
    input logic              host_clc,
    input logic              host_ota,
    input logic [DATA_W-1:0] host_data,
    input logic              dma_clc,
    input logic              svc_req,
    input logic              sector_end,
    input logic              hold_act,
    input logic              ctl_bit,
    input logic              run,
    input logic              svc_flag,
    input logic [TRK_W-1:0]  track,
    input logic              read_en,
    input logic              write_en
);

    logic clr_any;
    assign clr_any = dma_clc | (host_clc & dat_sel);

    // R1: addressed set-control with no clear, preset or hold-off sets the bit
    assert_stc_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stc && dat_sel && !clr_any && !preset_pulse && !hold_act) |=> ctl_bit);

    // R2: any clear wins over a simultaneous set
    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> !ctl_bit);

    // R3: run persists while the control bit is set
    assert_run_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl_bit && !preset_pulse) |=> run);

    // R4: run drops only on a sector end or preset
    assert_run_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sector_end && !preset_pulse) |=> run);

    // R6: preset clears the control state
    assert_preset_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        preset_pulse |=> (!ctl_bit && !run && !svc_flag));

    // R5: a flag without a request never appears
    assert_flag_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_flag && !(svc_req && run)) |=> !svc_flag);

    // R7: no qualifier without run
    assert_idle_no_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!read_en && !write_en));

    // R8: power not good blocks writing
    assert_pwr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> !write_en);

    // R9: load takes the host field
    assert_track_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ota && cmd_sel) |=> (track == $past(host_data[TRK_LSB +: TRK_W])));

    // R10: without a load the track address is stable
    assert_track_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ota && cmd_sel) |=> $stable(track));

endmodule

bind disc_chan_ctl disc_chan_ctl_chk #(
    .DATA_W  (DATA_W),
    .TRK_W   (TRK_W),
    .TRK_LSB (TRK_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .preset_pulse (preset_pulse),
    .pwr_ok       (pwr_ok),
    .dat_sel      (dat_sel),
    .cmd_sel      (cmd_sel),
    .host_stc     (host_stc),
    .host_clc     (host_clc),
    .host_ota     (host_ota),
    .host_data    (host_data),
    .dma_clc      (dma_clc),
    .svc_req      (svc_req),
    .sector_end   (sector_end),
    .hold_act     (hold_act),
    .ctl_bit      (ctl_bit),
    .run          (run),
    .svc_flag     (svc_flag),
    .track        (track),
    .read_en      (read_en),
    .write_en     (write_en)
);

// File: tb/test_disc_chan_ctl.sv
`timescale 1ns/1ps
module test_disc_chan_ctl;

    localparam int DATA_W = 16;
    localparam int TRK_W  = 7;
    localparam int HOLD   = 12;

    logic clk = 1'b0;
    logic rst_n, preset_pulse, pwr_ok, dat_sel, cmd_sel;
    logic host_stc, host_clc, host_clf, host_ota;
    logic [DATA_W-1:0] host_data;
    logic dma_clc, dma_clf, svc_req, sector_end, wr_mode;
    logic ctl_bit, run, svc_flag, read_en, write_en;
    logic [TRK_W-1:0] track;

    int checks = 0;
    int errors = 0;

    // reference state
    logic m_ctl, m_run, m_flag;
    logic [TRK_W-1:0] m_trk;
    int m_hold;

    always #2.5 clk = ~clk;

    disc_chan_ctl #(.DATA_W(DATA_W), .TRK_W(TRK_W), .TRK_LSB(7), .HOLD_CYCLES(HOLD)) i_disc_chan_ctl (
        .clk(clk), .rst_n(rst_n), .preset_pulse(preset_pulse), .pwr_ok(pwr_ok),
        .dat_sel(dat_sel), .cmd_sel(cmd_sel), .host_stc(host_stc), .host_clc(host_clc),
        .host_clf(host_clf), .host_ota(host_ota), .host_data(host_data),
        .dma_clc(dma_clc), .dma_clf(dma_clf), .svc_req(svc_req), .sector_end(sector_end),
        .wr_mode(wr_mode), .ctl_bit(ctl_bit), .run(run), .svc_flag(svc_flag),
        .track(track), .read_en(read_en), .write_en(write_en));

    function automatic logic [TRK_W-1:0] trk_field(logic [DATA_W-1:0] d);
        return d[13:7];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference update from the requirements, using inputs held at the edge.
    task automatic model_edge();
        logic hold_on, clr, set, fset, fclr;
        if (!rst_n) begin
            m_ctl = 0; m_run = 0; m_flag = 0; m_trk = '0; m_hold = 0;
            return;
        end
        if (host_ota && cmd_sel) m_trk = trk_field(host_data);
        if (preset_pulse) begin
            m_ctl = 0; m_run = 0; m_flag = 0; m_hold = HOLD;
            return;
        end
        hold_on = (m_hold != 0);
        if (hold_on) m_hold--;
        clr  = dma_clc || (host_clc && dat_sel);
        set  = host_stc && dat_sel && !hold_on;
        fset = svc_req && m_run;
        fclr = dma_clf || (host_clf && dat_sel);
        if (m_ctl) m_run = 1; else if (sector_end) m_run = 0;
        if (fset) m_flag = 1; else if (fclr) m_flag = 0;
        if (clr) m_ctl = 0; else if (set) m_ctl = 1;
    endtask

    task automatic compare_all();
        chk("R1 R2 ctl_bit", 32'(ctl_bit), 32'(m_ctl));
        chk("R3 R4 run", 32'(run), 32'(m_run));
        chk("R5 svc_flag", 32'(svc_flag), 32'(m_flag));
        chk("R7 read_en", 32'(read_en), 32'(m_run && !wr_mode));
        chk("R7 R8 write_en", 32'(write_en), 32'(m_run && wr_mode && pwr_ok));
        chk("R9 R10 track", 32'(track), 32'(m_trk));
    endtask

    // Inputs are set at the falling edge; one rising edge; compare after it.
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic idle();
        preset_pulse = 0; host_stc = 0; host_clc = 0; host_clf = 0; host_ota = 0;
        dma_clc = 0; dma_clf = 0; svc_req = 0; sector_end = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; pwr_ok = 1; dat_sel = 0; cmd_sel = 0; wr_mode = 0; host_data = '0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(); step();
        chk("R1 reset ctl_bit", 32'(ctl_bit), 0);
        chk("R10 reset track", 32'(track), 0);
        rst_n = 1;

        // R1 / R3: start transfer
        dat_sel = 1; host_stc = 1; step(); idle();
        chk("R1 stc sets", 32'(ctl_bit), 1);
        step();
        chk("R3 run follows", 32'(run), 1);
        // R11: unaddressed clear ignored
        dat_sel = 0; host_clc = 1; step(); idle();
        chk("R11 clc without select", 32'(ctl_bit), 1);
        // R3: sector end with control set keeps running
        sector_end = 1; step(); idle();
        chk("R3 run across sector", 32'(run), 1);
        // R5: flag set, unaddressed clear, DMA clear, request beats clear
        svc_req = 1; step(); idle();
        chk("R5 flag set", 32'(svc_flag), 1);
        host_clf = 1; dat_sel = 0; step(); idle();
        chk("R11 clf without select", 32'(svc_flag), 1);
        dma_clf = 1; step(); idle();
        chk("R5 dma clear", 32'(svc_flag), 0);
        svc_req = 1; dma_clf = 1; step(); idle();
        chk("R5 request wins", 32'(svc_flag), 1);
        // R7 / R8
        wr_mode = 1; #1;
        chk("R7 write_en", 32'(write_en), 1);
        pwr_ok = 0; #1;
        chk("R8 power low blocks write", 32'(write_en), 0);
        pwr_ok = 1; @(negedge clk);
        // R2 / R4: clear, run waits for sector end
        dat_sel = 1; host_clc = 1; step(); idle();
        chk("R2 clc clears", 32'(ctl_bit), 0);
        step(); step();
        chk("R4 run waits", 32'(run), 1);
        sector_end = 1; step(); idle();
        chk("R4 run ends at sector", 32'(run), 0);
        chk("R7 idle write_en", 32'(write_en), 0);
        // R2: set and clear together
        host_stc = 1; host_clc = 1; step(); idle();
        chk("R2 clear wins", 32'(ctl_bit), 0);
        // R9 / R10 / R11: track address mapping
        cmd_sel = 1; host_ota = 1; host_data = 16'h0080; step(); idle();
        chk("R9 bit7 to track0", 32'(track), 1);
        host_ota = 1; host_data = 16'hC07F; step(); idle();
        chk("R9 field only", 32'(track), 0);
        host_ota = 1; host_data = 16'h3F80; step(); idle();
        chk("R9 full field", 32'(track), 7'h7F);
        cmd_sel = 0; host_ota = 1; host_data = 16'h0000; step(); idle();
        chk("R11 ota without select", 32'(track), 7'h7F);
        // R6: preset train with gaps, stc ignored until window closes
        dat_sel = 1; host_stc = 1; step(); idle(); step();
        preset_pulse = 1; step(); idle();
        chk("R6 preset clears ctl", 32'(ctl_bit), 0);
        chk("R6 preset clears run", 32'(run), 0);
        chk("R10 track through preset", 32'(track), 7'h7F);
        step(); step();
        preset_pulse = 1; step(); idle();
        host_stc = 1; step(); idle();
        chk("R6 stc in gap ignored", 32'(ctl_bit), 0);
        repeat (HOLD - 2) step();
        host_stc = 1; step(); idle();
        chk("R6 stc at window end ignored", 32'(ctl_bit), 0);
        host_stc = 1; step(); idle();
        chk("R6 stc after window", 32'(ctl_bit), 1);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            preset_pulse = ($urandom % 97) == 0;
            pwr_ok     = ($urandom % 10) != 0;
            dat_sel    = ($urandom % 4) != 0;
            cmd_sel    = ($urandom % 2) == 0;
            host_stc   = ($urandom % 5) == 0;
            host_clc   = ($urandom % 9) == 0;
            host_clf   = ($urandom % 6) == 0;
            host_ota   = ($urandom % 7) == 0;
            host_data  = 16'($urandom);
            dma_clc    = ($urandom % 15) == 0;
            dma_clf    = ($urandom % 5) == 0;
            svc_req    = ($urandom % 3) == 0;
            sector_end = ($urandom % 8) == 0;
            wr_mode    = ($urandom % 2) == 0;
            rst_n      = ($urandom % 1500) != 0;
            step();
        end
        rst_n = 1; idle(); step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule